// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block resolves branches for a 32-bit fixed-width instruction word. For each instruction it is given, it decides whether the branch is taken and returns the next program counter, the updated count register and the updated link register. It accepts four branch encodings: the immediate conditional branch, the long unconditional branch, and the two register-target conditional branches (to link and to count). A conditional branch can take a 5-bit option field that decrements the count register and tests it, tests one bit of the 32-bit condition register, or does both.

The resolution logic is purely combinational. A parameter selects whether the results reach the outputs directly or through an output register. The registered variant loads all four results on the clock edge where the valid strobe is high. It holds them at every other edge. The datapath width is a parameter and must be greater than 32. A mode input truncates addresses to 32 bits.

Top module: `branch_resolve_unit`

## Requirements
- R1: Encodings are recognised by primary opcode in bits 31..26: 16 is the immediate conditional branch, 18 is the long unconditional branch, and 19 is a register-target branch when bits 10..1 equal 16 (to link) or 528 (to count). Any other word yields next PC = PC+4, taken low, and count and link unchanged.
- R2: The option field is bits 25..21. In a conditional form, when option bit 2 (instruction bit 23) is clear, the count register is decremented by one. When it is set, the count register is left unchanged.
- R3: When option bit 2 is clear, the counter test uses the new count. With option bit 1 (instruction bit 22) set, the test passes only if the new count is zero. With option bit 1 clear, it passes only if the new count is nonzero. When option bit 2 is set, the counter test passes.
- R4: When option bit 4 (instruction bit 25) is clear, the condition register bit at position 31−i must equal option bit 3 (instruction bit 24). Here i is the index in instruction bits 20..16, so index 0 is the MSB. When option bit 4 is set, the condition test passes.
- R5: A conditional branch is taken only when both tests pass. A branch that is not taken sets next PC to PC+4.
- R6: The immediate conditional target uses displacement bits 15..2 with two zero bits appended, sign-extended. Instruction bit 1 set makes this displacement the absolute target. Bit 1 clear adds it to PC.
- R7: The long unconditional form is always taken and leaves the count register unchanged. Its displacement is bits 25..2 with two zero bits appended, sign-extended from bit 25. The same bit-1 absolute/relative choice applies.
- R8: A register-target branch goes to the incoming count register value when instruction bit 10 is set. Otherwise it goes to the incoming link register value.
- R9: In any recognised branch with instruction bit 0 set, the link output is PC+4, whether or not the branch is taken. The target is still read from the incoming link value. With bit 0 clear, the link register is unchanged.
- R10: With the 32-bit mode input high, the next PC and the written link value have their upper bits cleared.
- R11: In the registered variant, all outputs are zero in reset. They load on the clock edge where valid_i is high and hold at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Load strobe for the output register |
| insn_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| ctr_i | input | XLEN | Current count register |
| lr_i | input | XLEN | Current link register |
| cr_i | input | 32 | Condition register |
| mode32_i | input | 1 | Truncate addresses to 32 bits |
| next_pc_o | output | XLEN | Resolved next instruction address |
| ctr_o | output | XLEN | Updated count register |
| lr_o | output | XLEN | Updated link register |
| taken_o | output | 1 | Branch taken |

## Verification
In the default registered variant, every output belongs to the strobe sampled at the previous rising edge. No result is due in the same cycle as its strobe. The driver applies each instruction on a falling edge and queues its expected result. The monitor records at each rising edge whether the strobe was high, and pops and compares at the next falling edge, exactly one cycle after the stimulus. Hold behaviour is checked by changing the inputs with the strobe low and sampling two falling edges later.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned CR_W   = 32;

  localparam logic [5:0] OP_BC_IMM = 6'd16;
  localparam logic [5:0] OP_B_LONG = 6'd18;
  localparam logic [5:0] OP_XL     = 6'd19;
  localparam logic [9:0] XO_TO_LR  = 10'd16;
  localparam logic [9:0] XO_TO_CTR = 10'd528;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_BC_IMM,
    FORM_B_LONG,
    FORM_BC_REG
  } form_e;

  typedef struct packed {
    form_e      form;
    logic [4:0] opt;
    logic [4:0] bit_idx;
    logic       abs_tgt;
    logic       set_link;
    logic       use_ctr;
  } dec_t;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  logic [5:0] op;
  logic [9:0] xo;

  assign op = insn_i[31:26];
  assign xo = insn_i[10:1];

  always_comb begin
    dec_o.form = FORM_NONE;
    unique case (op)
      OP_BC_IMM: dec_o.form = FORM_BC_IMM;
      OP_B_LONG: dec_o.form = FORM_B_LONG;
      OP_XL:     if (xo == XO_TO_LR || xo == XO_TO_CTR) dec_o.form = FORM_BC_REG;
      default:   dec_o.form = FORM_NONE;
    endcase
    dec_o.opt      = insn_i[25:21];
    dec_o.bit_idx  = insn_i[20:16];
    dec_o.abs_tgt  = insn_i[1];
    dec_o.set_link = insn_i[0];
    dec_o.use_ctr  = insn_i[10];
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  dec_t             dec_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [XLEN-1:0]  ctr_i,
  output logic [XLEN-1:0]  ctr_o,
  output logic             pass_o
);
  logic is_cond, dec_en, new_zero, ctr_ok, cr_bit, cr_ok;

  assign is_cond = (dec_i.form == FORM_BC_IMM) || (dec_i.form == FORM_BC_REG);
  assign dec_en  = is_cond && !dec_i.opt[2];
  assign ctr_o   = dec_en ? ctr_i - XLEN'(1) : ctr_i;

  // zero test of the new count without waiting on the decrement carry chain
  assign new_zero = dec_en ? (ctr_i == XLEN'(1)) : (ctr_i == '0);
  assign ctr_ok   = dec_i.opt[2] || (new_zero == dec_i.opt[1]);

  // index 0 selects the MSB
  assign cr_bit = cr_i[5'd31 - dec_i.bit_idx];
  assign cr_ok  = dec_i.opt[4] || (cr_bit == dec_i.opt[3]);

  assign pass_o = !is_cond || (ctr_ok && cr_ok);
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  dec_t              dec_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   ctr_i,
  input  logic [XLEN-1:0]   lr_i,
  input  logic              mode32_i,
  output logic [XLEN-1:0]   tgt_o,
  output logic [XLEN-1:0]   seq_o
);
  localparam int unsigned HI_W = XLEN - 32;

  logic [XLEN-1:0] mask, disp_short, disp_long, disp, raw;

  assign mask       = {{HI_W{!mode32_i}}, 32'hFFFF_FFFF};
  assign disp_short = {{(XLEN-16){insn_i[15]}}, insn_i[15:2], 2'b00};
  assign disp_long  = {{(XLEN-26){insn_i[25]}}, insn_i[25:2], 2'b00};
  assign disp       = (dec_i.form == FORM_B_LONG) ? disp_long : disp_short;

  always_comb begin
    if (dec_i.form == FORM_BC_REG) raw = dec_i.use_ctr ? ctr_i : lr_i;
    else if (dec_i.abs_tgt)        raw = disp;
    else                           raw = pc_i + disp;
  end

  assign tgt_o = raw & mask;
  assign seq_o = (pc_i + XLEN'(4)) & mask;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brc_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   ctr_i,
  input  logic [XLEN-1:0]   lr_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic              mode32_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   ctr_o,
  output logic [XLEN-1:0]   lr_o,
  output logic              taken_o
);
  dec_t            dec;
  logic [XLEN-1:0] ctr_upd, tgt, seq;
  logic            pass, is_br, taken_c;
  logic [XLEN-1:0] npc_c, lr_c;

  brc_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  brc_cond_eval #(.XLEN(XLEN)) u_cond (
    .dec_i(dec), .cr_i(cr_i), .ctr_i(ctr_i), .ctr_o(ctr_upd), .pass_o(pass)
  );

  brc_target_gen #(.XLEN(XLEN)) u_tgt (
    .dec_i(dec), .insn_i(insn_i), .pc_i(pc_i), .ctr_i(ctr_i), .lr_i(lr_i),
    .mode32_i(mode32_i), .tgt_o(tgt), .seq_o(seq)
  );

  assign is_br   = (dec.form != FORM_NONE);
  assign taken_c = is_br && pass;
  assign npc_c   = taken_c ? tgt : seq;
  assign lr_c    = (is_br && dec.set_link) ? seq : lr_i;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          next_pc_o <= '0;
          ctr_o     <= '0;
          lr_o      <= '0;
          taken_o   <= 1'b0;
        end else if (valid_i) begin
          next_pc_o <= npc_c;
          ctr_o     <= ctr_upd;
          lr_o      <= lr_c;
          taken_o   <= taken_c;
        end
      end

      // R11
      hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(next_pc_o) && $stable(ctr_o) && $stable(lr_o) && $stable(taken_o)));

      // R5
      fallthrough_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (taken_o || next_pc_o ==
          (($past(pc_i) + XLEN'(4)) & {{(XLEN-32){!$past(mode32_i)}}, 32'hFFFF_FFFF})));

      // R9
      link_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !insn_i[0]) |=> (lr_o == $past(lr_i)));

      // R7
      long_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && insn_i[31:26] == OP_B_LONG) |=> (taken_o && ctr_o == $past(ctr_i)));

      // R2
      no_decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && insn_i[23]) |=> (ctr_o == $past(ctr_i)));

      // R10
      upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mode32_i) |=> (next_pc_o[XLEN-1:32] == '0));
    end else begin : g_comb
      assign next_pc_o = npc_c;
      assign ctr_o     = ctr_upd;
      assign lr_o      = lr_c;
      assign taken_o   = taken_c;
    end
  endgenerate
endmodule

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
module branch_resolve_unit_test;
  localparam int XLEN = 64;

  typedef struct {
    logic [63:0] npc;
    logic [63:0] ctr;
    logic [63:0] lr;
    logic        taken;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] pc = '0, ctr = '0, lr = '0;
  logic [31:0] cr = '0;
  logic        m32 = 1'b0;
  logic [63:0] npc_o, ctr_o, lr_o;
  logic        taken_o;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  exp_t last_exp;
  bit   done = 0;

  always #10 clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn), .pc_i(pc),
    .ctr_i(ctr), .lr_i(lr), .cr_i(cr), .mode32_i(m32),
    .next_pc_o(npc_o), .ctr_o(ctr_o), .lr_o(lr_o), .taken_o(taken_o)
  );

  function automatic logic [31:0] mk_bc(logic [4:0] bo, logic [4:0] bi, logic [15:0] bd,
                                        logic aa, logic lk);
    return {6'd16, bo, bi, bd[15:2], aa, lk};
  endfunction

  function automatic logic [31:0] mk_b(logic [25:0] li, logic aa, logic lk);
    return {6'd18, li[25:2], aa, lk};
  endfunction

  function automatic logic [31:0] mk_br(logic [4:0] bo, logic [4:0] bi, logic to_ctr, logic lk);
    return {6'd19, bo, bi, 5'd0, (to_ctr ? 10'd528 : 10'd16), lk};
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [63:0] p, logic [63:0] c,
                                 logic [63:0] l, logic [31:0] crv, logic m, string req);
    exp_t r;
    logic [63:0] msk, seq, tgt, newc;
    logic [4:0]  bo, bi;
    logic        f_bc, f_b, f_reg, okc, okr;
    msk   = m ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
    seq   = (p + 64'd4) & msk;
    bo    = w[25:21];
    bi    = w[20:16];
    f_bc  = (w[31:26] == 6'd16);
    f_b   = (w[31:26] == 6'd18);
    f_reg = (w[31:26] == 6'd19) && (w[10:1] == 10'd16 || w[10:1] == 10'd528);
    r.npc = seq; r.ctr = c; r.lr = l; r.taken = 1'b0; r.req = req;
    if (f_b) begin
      tgt = {{38{w[25]}}, w[25:2], 2'b00};
      if (!w[1]) tgt = tgt + p;
      r.taken = 1'b1;
      r.npc   = tgt & msk;
    end else if (f_bc || f_reg) begin
      newc = bo[2] ? c : c - 64'd1;
      r.ctr = newc;
      okc = bo[2] ? 1'b1 : (bo[1] ? (newc == 0) : (newc != 0));
      okr = bo[4] ? 1'b1 : (crv[31 - int'(bi)] == bo[3]);
      r.taken = okc && okr;
      if (f_reg) tgt = w[10] ? c : l;
      else begin
        tgt = {{48{w[15]}}, w[15:2], 2'b00};
        if (!w[1]) tgt = tgt + p;
      end
      if (r.taken) r.npc = tgt & msk;
    end
    if ((f_b || f_bc || f_reg) && w[0]) r.lr = seq;
    return r;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (npc_o !== e.npc || ctr_o !== e.ctr || lr_o !== e.lr || taken_o !== e.taken) begin
      fails++;
      $display("FAIL %s: got npc=%h ctr=%h lr=%h tk=%b exp npc=%h ctr=%h lr=%h tk=%b",
               e.req, npc_o, ctr_o, lr_o, taken_o, e.npc, e.ctr, e.lr, e.taken);
    end
  endtask

  task automatic drive(logic [31:0] w, logic [63:0] p, logic [63:0] c, logic [63:0] l,
                       logic [31:0] crv, logic m, string req);
    @(negedge clk);
    insn = w; pc = p; ctr = c; lr = l; cr = crv; m32 = m; valid = 1'b1;
    last_exp = model(w, p, c, l, crv, m, req);
    q.push_back(last_exp);
  endtask

  // monitor: a strobe seen at a rising edge is due at the following falling edge
  initial begin
    bit pend;
    forever begin
      @(posedge clk);
      pend = valid;
      @(negedge clk);
      if (pend && q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] P;
    P = 64'h0000_0001_0000_1000;
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (npc_o !== 0 || ctr_o !== 0 || lr_o !== 0 || taken_o !== 0) begin
      fails++;
      $display("FAIL R11 reset: got %h %h %h %b exp zeros", npc_o, ctr_o, lr_o, taken_o);
    end
    rst_n = 1'b1;

    // R5 both tests disabled, backward relative
    drive(mk_bc(5'b10100, 5'd0, 16'hFFF0, 1'b0, 1'b0), P, 64'd7, 64'h55, 32'h0, 1'b0, "R5");
    // R2 R3 decrement, branch on nonzero
    drive(mk_bc(5'b10000, 5'd0, 16'h0040, 1'b0, 1'b0), P, 64'd5, 64'h55, 32'h0, 1'b0, "R3");
    drive(mk_bc(5'b10000, 5'd0, 16'h0040, 1'b0, 1'b0), P, 64'd1, 64'h55, 32'h0, 1'b0, "R2");
    // R3 branch on zero; wrap from zero
    drive(mk_bc(5'b10010, 5'd0, 16'h0040, 1'b0, 1'b0), P, 64'd1, 64'h55, 32'h0, 1'b0, "R3");
    drive(mk_bc(5'b10010, 5'd0, 16'h0040, 1'b0, 1'b0), P, 64'd0, 64'h55, 32'h0, 1'b0, "R3");
    // R4 condition bit tests, index 0 is MSB
    drive(mk_bc(5'b01100, 5'd0, 16'h0100, 1'b0, 1'b0), P, 64'd3, 64'h55, 32'h8000_0000, 1'b0, "R4");
    drive(mk_bc(5'b01100, 5'd31, 16'h0100, 1'b0, 1'b0), P, 64'd3, 64'h55, 32'h8000_0000, 1'b0, "R4");
    drive(mk_bc(5'b00100, 5'd2, 16'h0100, 1'b0, 1'b0), P, 64'd3, 64'h55, 32'hDFFF_FFFF, 1'b0, "R4");
    // R5 combined tests
    drive(mk_bc(5'b01000, 5'd4, 16'h0020, 1'b0, 1'b0), P, 64'd3, 64'h55, 32'h0800_0000, 1'b0, "R5");
    drive(mk_bc(5'b01000, 5'd4, 16'h0020, 1'b0, 1'b0), P, 64'd1, 64'h55, 32'h0800_0000, 1'b0, "R5");
    // R6 absolute target with link R9
    drive(mk_bc(5'b10100, 5'd0, 16'h8004, 1'b1, 1'b1), P, 64'd9, 64'h55, 32'h0, 1'b0, "R6");
    // R7 long backward with link
    drive(mk_b(26'h3FF_FF00, 1'b0, 1'b1), P, 64'd9, 64'h55, 32'h0, 1'b0, "R7");
    drive(mk_b(26'h100_0000, 1'b1, 1'b0), P, 64'd9, 64'h55, 32'h0, 1'b0, "R7");
    // R8 R9 to link, link overwritten after read
    drive(mk_br(5'b10100, 5'd0, 1'b0, 1'b1), P, 64'h0000_0000_0000_2000,
          64'h0000_0002_0000_0300, 32'h0, 1'b0, "R8");
    drive(mk_br(5'b10100, 5'd0, 1'b1, 1'b0), P, 64'h0000_0003_0000_0440,
          64'h77, 32'h0, 1'b0, "R8");
    // R9 not-taken with link still writes
    drive(mk_bc(5'b01100, 5'd1, 16'h0100, 1'b0, 1'b1), P, 64'd3, 64'h55, 32'h0, 1'b0, "R9");
    // R10 truncation
    drive(mk_bc(5'b01100, 5'd1, 16'h0100, 1'b0, 1'b1), 64'h0000_0000_FFFF_FFFC, 64'd3,
          64'h55, 32'h0, 1'b1, "R10");
    drive(mk_b(26'h000_0100, 1'b0, 1'b1), 64'h0000_0001_FFFF_FF00, 64'd3, 64'h55,
          32'h0, 1'b1, "R10");
    // R1 non-branch words
    drive(32'h7C00_0214, P, 64'd3, 64'h55, 32'hFFFF_FFFF, 1'b0, "R1");
    drive({6'd19, 5'b10100, 5'd0, 5'd0, 10'd150, 1'b1}, P, 64'd3, 64'h55, 32'h0, 1'b0, "R1");
    @(negedge clk);
    valid = 1'b0;
    // R11 hold with strobe low
    insn = mk_b(26'h000_0040, 1'b1, 1'b1); pc = 64'h1234; ctr = 64'd99; lr = 64'd88;
    repeat (2) @(negedge clk);
    last_exp.req = "R11 hold";
    compare(last_exp);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule